// File: doc/BRIEF.md
# Legacy Region Shadow Attribute Controller

This block lives in a memory controller and routes every CPU access that falls in the legacy upper area (0xC0000 to 0xFFFFF) either to shadow RAM or to the boot ROM. The routing follows seven attribute bytes that firmware loads through a byte-wide register port. The top 64 KB, where the boot code sits, has one attribute nibble of its own. The area from 0xC0000 to 0xEFFFF is cut into twelve 16 KB segments, and each of them has its own nibble.

Reads and writes are steered separately. A segment can be read from ROM while writes land in RAM, which is how firmware copies ROM into shadow RAM. The segment can then be switched to read from RAM and made read-only. Writes to a segment that is not write-enabled are dropped and flagged. Accesses below the legacy area pass through as ordinary memory accesses. All select outputs are combinational from the address, the strobes and the stored attributes.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: After reset all seven attribute registers read back 0x00, so every read in the legacy area selects ROM (rom_sel) and every write there is dropped (wr_drop).
- R2: Registers are written and read at cfg_addr 0x59 to 0x5F, and readback returns the last byte written. A write to any other offset changes nothing, and reading any other offset returns 0x00.
- R3: Bit 0 of a segment nibble is the read enable. A read (mem_rd=1, mem_wr=0) selects shadow_ram_sel when the bit is set and rom_sel when it is clear.
- R4: Bit 1 of a segment nibble is the write enable. A write selects shadow_ram_sel when the bit is set. When it is clear, wr_drop asserts and neither RAM nor ROM is selected.
- R5: Bits 2 and 3 of a nibble, and the whole low nibble of register 0x59, have no effect on routing.
- R6: Bits 7:4 of register 0x59 govern 0xF0000 to 0xFFFFF.
- R7: Each register from 0x5A to 0x5F covers two 16 KB segments in rising order, starting with 0x5A at 0xC0000. Bits 3:0 govern the lower segment and bits 7:4 the upper one.
- R8: An access below 0xC0000 asserts plain_ram_sel only. shadow_ram_sel, rom_sel and wr_drop stay low.
- R9: When mem_rd and mem_wr are both high, the write rule of R4 applies.
- R10: With no strobe high, all four select outputs are low. At most one select output is high at any time, and the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_addr | input | 8 | Attribute register offset |
| cfg_wdata | input | 8 | Attribute write data |
| cfg_rdata | output | 8 | Attribute readback for cfg_addr |
| mem_addr | input | 20 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| shadow_ram_sel | output | 1 | Access goes to shadow RAM |
| rom_sel | output | 1 | Read goes to boot ROM |
| wr_drop | output | 1 | Write is discarded |
| plain_ram_sel | output | 1 | Access outside the legacy area |

## Verification
A wrong stored attribute, or a segment mapped to the wrong nibble, appears at once as a flipped RAM or ROM choice on the very next access to that segment. It also appears as a changed readback byte. The bench therefore writes distinct patterns to neighbouring nibbles and probes both 16 KB halves of a register, and the edges of each range. A register latched at the wrong offset shows up in the cycle after the write, both as a readback mismatch and as a routing change in a segment that should not have moved.

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl #(
  parameter int          ADDR_W   = 20,
  parameter int          CFG_W    = 8,
  parameter logic [7:0]  BASE_OFS = 8'h59,
  parameter int          NREG     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic              shadow_ram_sel,
  output logic              rom_sel,
  output logic              wr_drop,
  output logic              plain_ram_sel
);
  localparam int IW = $clog2(NREG);

  logic [7:0] attr [NREG];

  logic [CFG_W-1:0] ofs;
  logic             cfg_hit;
  logic [IW-1:0]    cfg_idx;
  assign ofs     = cfg_addr - CFG_W'(BASE_OFS);
  assign cfg_hit = ofs < CFG_W'(NREG);
  assign cfg_idx = ofs[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) attr[i] <= 8'h00;
    end else if (cfg_we && cfg_hit) begin
      attr[cfg_idx] <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_hit ? attr[cfg_idx] : 8'h00;

  logic       top_seg, mid_seg, legacy;
  logic [3:0] seg;
  logic [IW-1:0] mid_idx;
  logic [3:0] nib;
  logic       unused_low;

  assign top_seg    = mem_addr[ADDR_W-1 -: 4] == 4'hF;
  assign mid_seg    = mem_addr[ADDR_W-1 -: 2] == 2'b11 && mem_addr[ADDR_W-3 -: 2] != 2'b11;
  assign legacy     = top_seg | mid_seg;
  assign seg        = mem_addr[ADDR_W-3 -: 4];
  assign mid_idx    = mid_seg ? IW'(seg[3:1]) + IW'(1) : '0;
  assign unused_low = ^mem_addr[ADDR_W-7:0];

  always_comb begin
    if (top_seg)      nib = attr[0][7:4];
    else if (mid_seg) nib = seg[0] ? attr[mid_idx][7:4] : attr[mid_idx][3:0];
    else              nib = 4'h0;
  end

  assign shadow_ram_sel = legacy & (mem_wr ? nib[1] : (mem_rd & nib[0]));
  assign rom_sel        = legacy & ~mem_wr & mem_rd & ~nib[0];
  assign wr_drop        = legacy & mem_wr & ~nib[1];
  assign plain_ram_sel  = ~legacy & (mem_rd | mem_wr);
endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [19:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        shadow_ram_sel,
  input logic        rom_sel,
  input logic        wr_drop,
  input logic        plain_ram_sel
);
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shadow_ram_sel, rom_sel, wr_drop, plain_ram_sel})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |-> !(shadow_ram_sel || rom_sel || wr_drop || plain_ram_sel)); // R10

  AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (mem_rd && !mem_wr)); // R9

  AST_LOW_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && mem_addr < 20'hC0000) |-> (plain_ram_sel && !shadow_ram_sel)); // R8

  AST_TOP_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h59 && !cfg_wdata[5]) |=>
      (!(mem_wr && mem_addr[19:16] == 4'hF) || wr_drop)); // R4

  AST_TOP_RD_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h59 && !cfg_wdata[4]) |=>
      (!(mem_rd && !mem_wr && mem_addr[19:16] == 4'hF) || rom_sel)); // R3

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (!$stable(cfg_addr) || $stable(cfg_rdata))); // R2
endmodule

bind shadow_attr_ctrl shadow_attr_chk u_chk (.*);

// File: tb/test_shadow_attr_ctrl.sv
module test_shadow_attr_ctrl;
  logic clk = 0, rst_n = 0, cfg_we = 0, mem_rd = 0, mem_wr = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic [19:0] mem_addr = 0;
  logic shadow_ram_sel, rom_sel, wr_drop, plain_ram_sel;

  always #4 clk = ~clk;

  shadow_attr_ctrl i_shadow_attr_ctrl (.*);

  typedef struct {
    string      tag;
    logic [3:0] sel;
    bit         chk_rd;
    logic [7:0] rd;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [3:0] RAM = 4'b1000, ROM = 4'b0100, DRP = 4'b0010, PLN = 4'b0001, NON = 4'b0000;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [3:0] got;
      it  = q.pop_front();
      got = {shadow_ram_sel, rom_sel, wr_drop, plain_ram_sel};
      checks++;
      if (got !== it.sel || (it.chk_rd && cfg_rdata !== it.rd)) begin
        fails++;
        $display("FAIL %s: sel=%b rdata=%h expected sel=%b rdata=%h", it.tag, got, cfg_rdata, it.sel, it.rd);
      end
    end
  end

  task automatic acc(input logic [19:0] a, input logic rd, input logic wr, input logic [3:0] es, input string tag);
    @(posedge clk); #1;
    mem_addr = a; mem_rd = rd; mem_wr = wr;
    q.push_back('{tag, es, 1'b0, 8'h00});
  endtask

  task automatic rdback(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    mem_rd = 0; mem_wr = 0; cfg_addr = a;
    q.push_back('{tag, NON, 1'b1, exp});
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    mem_rd = 0; mem_wr = 0; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int r = 8'h59; r <= 8'h5F; r++) rdback(8'(r), 8'h00, "R1 reset readback");
    acc(20'hC0000, 1, 0, ROM, "R1 reset read C0000");
    acc(20'hF8000, 1, 0, ROM, "R1 reset read F8000");
    acc(20'hE0000, 0, 1, DRP, "R1 reset write E0000");

    wreg(8'h58, 8'hFF);
    wreg(8'h60, 8'hFF);
    rdback(8'h58, 8'h00, "R2 offset 58 ignored");
    rdback(8'h60, 8'h00, "R2 offset 60 ignored");
    acc(20'hC0000, 1, 0, ROM, "R2 stray writes no routing effect");

    wreg(8'h5A, 8'h21);
    rdback(8'h5A, 8'h21, "R2 readback 5A");
    acc(20'hC1234, 1, 0, RAM, "R3 R7 read low half 5A");
    acc(20'hC2000, 0, 1, DRP, "R4 write low half not enabled");
    acc(20'hC5000, 1, 0, ROM, "R7 read high half 5A");
    acc(20'hC7FFF, 0, 1, RAM, "R4 R7 write high half 5A");
    acc(20'hC0000, 1, 1, DRP, "R9 write wins over read");
    acc(20'hC0000, 0, 0, NON, "R10 idle");

    wreg(8'h5C, 8'h10);
    acc(20'hD0000, 1, 0, ROM, "R7 5C lower segment");
    acc(20'hD4000, 1, 0, RAM, "R7 5C upper segment");

    wreg(8'h5F, 8'h1C);
    acc(20'hE8000, 1, 0, ROM, "R5 cache/reserved bits no read effect");
    acc(20'hEBFFF, 0, 1, DRP, "R5 cache/reserved bits no write effect");
    acc(20'hEC000, 1, 0, RAM, "R7 5F upper segment");
    acc(20'hEFFFF, 1, 0, RAM, "R7 5F top edge");

    wreg(8'h59, 8'h2F);
    rdback(8'h59, 8'h2F, "R2 readback 59");
    acc(20'hF0000, 1, 0, ROM, "R5 R6 59 low nibble ignored");
    acc(20'hF0000, 0, 1, RAM, "R6 write F0000 enabled");
    acc(20'hFFFFF, 0, 1, RAM, "R6 write FFFFF enabled");
    acc(20'hD8000, 1, 0, ROM, "R5 59 low nibble not C-E area");

    acc(20'h9FFFF, 1, 0, PLN, "R8 read below legacy");
    acc(20'h00000, 0, 1, PLN, "R8 write below legacy");
    acc(20'hBFFFF, 1, 0, PLN, "R8 read BFFFF");
    acc(20'hFFFFF, 0, 0, NON, "R10 idle top");

    @(posedge clk); #1 mem_rd = 0; mem_wr = 0;
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule